// File: doc/BRIEF.md
# Last Exception Branch Recorder

This block remembers where control flow last jumped before an exception or interrupt arrived. It watches a stream of retired taken branches, each carrying a source and a target address. It keeps the most recent pair in a tracking register. When an exception or interrupt event is signalled, that pair is copied into two 64-bit record registers. Debug software can read them back later to see how the core reached the faulting code.

The processor operating mode at the moment of capture decides how many address bits the records keep. With the extended 64-bit mode off, only the low 32 bits are kept. With it on and the core in its 64-bit sub-mode, the full addresses are kept. In the compatibility sub-mode, the upper half of each record is forced to zero. A single read port with a select input returns either record.

Top module: `ler_recorder`

## Requirements
- R1: After reset both records read as zero.
- R2: Every cycle with `br_valid` high replaces the tracked branch pair with `br_src`/`br_dst`. The tracked pair resets to zero. Branches without an event leave the records unchanged.
- R3: On an event (`exc_valid` high) with `mode_ext_en`=1 and `mode_sub64`=1, the records take the full 64-bit tracked source and target one clock later.
- R4: On an event with `mode_ext_en`=0, bits [31:0] of each record take the tracked address and bits [63:32] become zero.
- R5: On an event with `mode_ext_en`=1 and `mode_sub64`=0 (compatibility), bits [63:32] of each record become zero and bits [31:0] take the tracked address.
- R6: When a branch and an event arrive in the same cycle, the records capture the pair tracked before that cycle. The new branch becomes the tracked pair for the next event.
- R7: The records hold their value, whatever the mode inputs do, until the next event. An event with no new branch recaptures the same tracked pair under the mode current at that event.
- R8: `rd_data` returns the source record when `rd_sel`=0 and the target record when `rd_sel`=1, combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | A taken branch retires this cycle |
| br_src | input | 64 | Address of the retiring branch |
| br_dst | input | 64 | Target address of the retiring branch |
| exc_valid | input | 1 | An exception or interrupt is taken this cycle |
| mode_ext_en | input | 1 | Extended 64-bit mode enabled |
| mode_sub64 | input | 1 | 1 = 64-bit sub-mode, 0 = compatibility sub-mode (used only when extended mode is on) |
| rd_sel | input | 1 | 0 selects the source record, 1 the target record |
| rd_data | output | 64 | Selected record contents |

## Verification
A wrong tracked pair stays hidden until the next event, then appears in both records one clock later. A wrong width decision shows at once as nonzero or missing upper halves after that capture. A record that drifts without an event is visible on the next read, so the bench reads both records after every cycle. The same-cycle branch and event case is driven on purpose, because an off-by-one-cycle tracker shows only there.

// File: rtl/ler_pkg.sv
// Package: shared types for the last exception branch recorder.
// Assumes the mode inputs are stable during the capture cycle.
package ler_pkg;

    // How much of an address a capture keeps.
    typedef enum logic [1:0] {
        CAP_LEGACY = 2'd0,   // extended mode off: low half only
        CAP_COMPAT = 2'd1,   // extended mode on, compatibility sub-mode
        CAP_FULL   = 2'd2    // extended mode on, 64-bit sub-mode
    } cap_width_e;

    // Map the raw mode inputs onto a capture width.
    function automatic cap_width_e decode_width(input logic ext_en, input logic sub64);
        if (!ext_en)
            return CAP_LEGACY;
        else if (sub64)
            return CAP_FULL;
        else
            return CAP_COMPAT;
    endfunction

endpackage

// File: rtl/ler_branch_track.sv
// Module: ler_branch_track
// Holds the source/target pair of the most recent taken branch.
// Assumes br_valid marks exactly one retiring taken branch per cycle.
module ler_branch_track #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_src,
    input  logic [ADDR_W-1:0] br_dst,
    output logic [ADDR_W-1:0] trk_src,
    output logic [ADDR_W-1:0] trk_dst
);

    // Track the latest branch pair; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_src <= '0;
            trk_dst <= '0;
        end else if (br_valid) begin
            trk_src <= br_src;
            trk_dst <= br_dst;
        end
    end

    // R2: with no branch the tracked pair does not move
    a_r2_track_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> ($stable(trk_src) && $stable(trk_dst)));

endmodule

// File: rtl/ler_width_mask.sv
// Module: ler_width_mask
// Trims a branch pair to the width allowed by the current operating mode.
// Assumes ADDR_W >= LOW_W; purely combinational.
module ler_width_mask
    import ler_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LOW_W  = 32
) (
    input  logic              mode_ext_en,
    input  logic              mode_sub64,
    input  logic [ADDR_W-1:0] in_src,
    input  logic [ADDR_W-1:0] in_dst,
    output logic [ADDR_W-1:0] out_src,
    output logic [ADDR_W-1:0] out_dst
);

    localparam int HIGH_W = ADDR_W - LOW_W;

    cap_width_e width_sel;

    // Decode the mode pins into a capture width.
    always_comb width_sel = decode_width(mode_ext_en, mode_sub64);

    generate
        if (HIGH_W > 0) begin : g_split
            // Pass full addresses or zero-extend the low half.
            always_comb begin
                unique case (width_sel)
                    CAP_FULL: begin
                        out_src = in_src;
                        out_dst = in_dst;
                    end
                    default: begin
                        out_src = {{HIGH_W{1'b0}}, in_src[LOW_W-1:0]};
                        out_dst = {{HIGH_W{1'b0}}, in_dst[LOW_W-1:0]};
                    end
                endcase
            end
        end else begin : g_narrow
            // Address no wider than the low half: nothing to trim.
            always_comb begin
                out_src = in_src;
                out_dst = in_dst;
            end
        end
    endgenerate

endmodule

// File: rtl/ler_record_bank.sv
// Module: ler_record_bank
// Stores the captured source/target records and serves the read port.
// Assumes cap_en is a single-cycle capture strobe.
module ler_record_bank #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] cap_src,
    input  logic [ADDR_W-1:0] cap_dst,
    input  logic              rd_sel,
    output logic [ADDR_W-1:0] rec_from,
    output logic [ADDR_W-1:0] rec_to,
    output logic [ADDR_W-1:0] rd_data
);

    // Load the records on a capture strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_from <= '0;
            rec_to   <= '0;
        end else if (cap_en) begin
            rec_from <= cap_src;
            rec_to   <= cap_dst;
        end
    end

    // Select one record for the read port.
    always_comb rd_data = rd_sel ? rec_to : rec_from;

    // R1: records are zero on the first cycle out of reset
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rec_from == '0 && rec_to == '0));

    // R7: records hold between captures
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ($stable(rec_from) && $stable(rec_to)));

endmodule

// File: rtl/ler_recorder.sv
// Module: ler_recorder (top)
// Tracks the last taken branch and records it when an exception or
// interrupt is taken, trimming the width by the mode at capture time.
// Assumes mode inputs are valid in any cycle where exc_valid is high.
module ler_recorder #(
    parameter int ADDR_W = 64,
    parameter int LOW_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_src,
    input  logic [ADDR_W-1:0] br_dst,
    input  logic              exc_valid,
    input  logic              mode_ext_en,
    input  logic              mode_sub64,
    input  logic              rd_sel,
    output logic [ADDR_W-1:0] rd_data
);

    logic [ADDR_W-1:0] trk_src, trk_dst;
    logic [ADDR_W-1:0] msk_src, msk_dst;
    logic [ADDR_W-1:0] rec_from, rec_to;

    ler_branch_track #(.ADDR_W(ADDR_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .br_valid(br_valid),
        .br_src  (br_src),
        .br_dst  (br_dst),
        .trk_src (trk_src),
        .trk_dst (trk_dst)
    );

    ler_width_mask #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_mask (
        .mode_ext_en(mode_ext_en),
        .mode_sub64 (mode_sub64),
        .in_src     (trk_src),
        .in_dst     (trk_dst),
        .out_src    (msk_src),
        .out_dst    (msk_dst)
    );

    ler_record_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (exc_valid),
        .cap_src (msk_src),
        .cap_dst (msk_dst),
        .rd_sel  (rd_sel),
        .rec_from(rec_from),
        .rec_to  (rec_to),
        .rd_data (rd_data)
    );

    // R3, R6: a full-width capture takes the pair tracked before the event cycle
    a_r3_full_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && mode_ext_en && mode_sub64) |=>
            (rec_from == $past(trk_src) && rec_to == $past(trk_dst)));

    generate
        if (ADDR_W > LOW_W) begin : g_chk_upper
            // R4, R5: narrow captures leave the upper half zero
            a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (exc_valid && !(mode_ext_en && mode_sub64)) |=>
                    (rec_from[ADDR_W-1:LOW_W] == '0 && rec_to[ADDR_W-1:LOW_W] == '0));
            // R4, R5: narrow captures keep the low half of the tracked pair
            a_r4_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
                (exc_valid && !(mode_ext_en && mode_sub64)) |=>
                    (rec_from[LOW_W-1:0] == $past(trk_src[LOW_W-1:0]) &&
                     rec_to[LOW_W-1:0]   == $past(trk_dst[LOW_W-1:0])));
        end
    endgenerate

endmodule

// File: tb/ler_recorder_test.sv
// Bench for ler_recorder: table walk, then directed reset and corner cases.
module ler_recorder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [63:0] br_src = '0;
    logic [63:0] br_dst = '0;
    logic        exc_valid = 1'b0;
    logic        mode_ext_en = 1'b0;
    logic        mode_sub64 = 1'b0;
    logic        rd_sel = 1'b0;
    logic [63:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    ler_recorder uut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_src(br_src),
        .br_dst(br_dst), .exc_valid(exc_valid), .mode_ext_en(mode_ext_en),
        .mode_sub64(mode_sub64), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    localparam logic [63:0] A_S = 64'hA5A5_0001_1234_5678;
    localparam logic [63:0] A_D = 64'hA5A5_0002_9ABC_DEF0;
    localparam logic [63:0] C_S = 64'hC0DE_0003_0000_1000;
    localparam logic [63:0] C_D = 64'hC0DE_0004_0000_2000;
    localparam logic [63:0] E_S = 64'hFFFF_FFFF_8000_0000;
    localparam logic [63:0] E_D = 64'h8000_0000_7FFF_FFFF;
    localparam logic [63:0] G_S = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] G_D = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] E_SL = 64'h0000_0000_8000_0000;
    localparam logic [63:0] E_DL = 64'h0000_0000_7FFF_FFFF;

    typedef struct packed {
        logic        brv;
        logic [63:0] src;
        logic [63:0] dst;
        logic        evt;
        logic        ext;
        logic        s64;
        logic [63:0] exp_from;
        logic [63:0] exp_to;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, A_S, A_D, 1'b0, 1'b1, 1'b1, 64'd0, 64'd0, 8'd2}, // R2 branch only
        '{1'b0, 64'd0, 64'd0, 1'b1, 1'b1, 1'b1, A_S, A_D, 8'd3}, // R3 full capture
        '{1'b1, C_S, C_D, 1'b0, 1'b1, 1'b1, A_S, A_D, 8'd2},     // R2 record unchanged
        '{1'b1, E_S, E_D, 1'b1, 1'b1, 1'b1, C_S, C_D, 8'd6},     // R6 same cycle
        '{1'b0, 64'd0, 64'd0, 1'b1, 1'b0, 1'b0, E_SL, E_DL, 8'd4}, // R4 legacy
        '{1'b0, 64'd0, 64'd0, 1'b1, 1'b1, 1'b0, E_SL, E_DL, 8'd5}, // R5 compat
        '{1'b0, 64'd0, 64'd0, 1'b1, 1'b1, 1'b1, E_S, E_D, 8'd7},   // R7 recapture
        '{1'b1, G_S, G_D, 1'b1, 1'b0, 1'b1, E_SL, E_DL, 8'd6},     // R6 with legacy width
        '{1'b0, 64'd0, 64'd0, 1'b0, 1'b1, 1'b0, E_SL, E_DL, 8'd7}, // R7 hold across mode change
        '{1'b0, 64'd0, 64'd0, 1'b1, 1'b1, 1'b1, G_S, G_D, 8'd3}    // R3 later branch
    };

    // Read both records through the port (R8) and compare.
    task automatic check_recs(input string tag, input logic [63:0] ef, input logic [63:0] et);
        rd_sel = 1'b0;
        #1;
        n_checks++;
        if (rd_data !== ef) begin
            n_fail++;
            $display("FAIL %s source record: actual %h expected %h", tag, rd_data, ef);
        end
        rd_sel = 1'b1;
        #1;
        n_checks++;
        if (rd_data !== et) begin
            n_fail++;
            $display("FAIL %s target record: actual %h expected %h", tag, rd_data, et);
        end
    endtask

    // Drive one cycle of stimulus at the falling edge, check after the rising edge.
    task automatic step(input logic brv, input logic [63:0] s, input logic [63:0] d,
                        input logic evt, input logic ext, input logic s64);
        @(negedge clk);
        br_valid = brv; br_src = s; br_dst = d;
        exc_valid = evt; mode_ext_en = ext; mode_sub64 = s64;
        @(posedge clk);
        #1;
    endtask

    initial begin
        string tag;
        repeat (3) @(posedge clk);
        #1;
        check_recs("R1 records zero in reset", 64'd0, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_recs("R1 records zero after reset", 64'd0, 64'd0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].brv, VECS[i].src, VECS[i].dst, VECS[i].evt, VECS[i].ext, VECS[i].s64);
            tag = $sformatf("R%0d vector %0d", VECS[i].req, i);
            check_recs(tag, VECS[i].exp_from, VECS[i].exp_to);
        end

        // R1: reset mid-run clears the records and the tracked pair
        step(1'b1, A_S, A_D, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        br_valid = 1'b0;
        exc_valid = 1'b0;
        @(posedge clk);
        #1;
        check_recs("R1 records cleared by reset", 64'd0, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: event with nothing tracked since reset captures zero
        step(1'b0, 64'd0, 64'd0, 1'b1, 1'b1, 1'b1);
        check_recs("R2 tracked pair reset to zero", 64'd0, 64'd0);

        // R6: branch and event together right after reset still capture zero
        step(1'b1, G_S, G_D, 1'b1, 1'b1, 1'b1);
        check_recs("R6 same cycle after reset", 64'd0, 64'd0);

        // R5: the branch from the same-cycle case is captured by the next event
        step(1'b0, 64'd0, 64'd0, 1'b1, 1'b1, 1'b0);
        check_recs("R5 compat capture of later branch", 64'h0000_0000_89AB_CDEF,
                   64'h0000_0000_7654_3210);

        // R2: back-to-back branches, only the last one counts
        step(1'b1, A_S, A_D, 1'b0, 1'b1, 1'b1);
        step(1'b1, C_S, C_D, 1'b0, 1'b1, 1'b1);
        check_recs("R2 branches without event", 64'h0000_0000_89AB_CDEF,
                   64'h0000_0000_7654_3210);
        step(1'b0, 64'd0, 64'd0, 1'b1, 1'b1, 1'b1);
        check_recs("R3 last of back-to-back branches", C_S, C_D);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule